// File: doc/BRIEF.md
# DMA Request Input Sampler

This block watches an active-low request pin driven by an external device and turns each qualifying request into a one-cycle transfer-start pulse for the DMA engine. The pin is first brought into the clock domain through a synchroniser. Two detection styles are available. In level mode, any sample that finds the pin low counts as a request. In edge mode, only a high-to-low transition counts, so a pin that is held low asks for exactly one transfer.

After a request is detected, the block does not look at the pin again until the engine raises its acknowledge. In the first cycle that acknowledge is high, the block takes one sample. If that sample qualifies, it is a new request and the block keeps waiting. If it does not, the block goes back to sampling on every clock. The transfer-start pulse trails the detection by a fixed number of cycles, never fewer than three.

Top module: `dma_req_sampler`

## Requirements
- R1: While `rst_n` is low, and in every cycle in which no detection has happened, `xfer_start` is low.
- R2: If the pin is captured low at clock edge k and that sample qualifies, detection happens in the cycle after edge k+1. `xfer_start` then goes high in the cycle after edge k+4, which is LAT_STATES (3) cycles after detection.
- R3: Each detection produces exactly one `xfer_start` cycle.
- R4: With `mode_edge` = 1, only a change of the synchronised pin from high to low is detected. A pin that stays low never causes a second detection, even after `ack_in` has been high.
- R5: With `mode_edge` = 0, a pin still low at the acknowledge sample is a new detection. `xfer_start` follows it 3 cycles after the `ack_in` cycle.
- R6: After a detection and before `ack_in` is next high, no activity on `req_in_n` causes a detection.
- R7: In the first cycle of the hold with `ack_in` high, the block takes one sample. If that sample does not qualify, sampling resumes on every cycle, and a later falling edge is detected with the R2 latency.
- R8: For the first SYNC_STAGES+1 (3) clock edges after reset release, nothing is detected. In edge mode, a pin held low through reset release is not counted as a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in_n | input | 1 | External DMA request, active low, asynchronous |
| mode_edge | input | 1 | 1: falling-edge detection, 0: low-level detection |
| ack_in | input | 1 | Transfer acknowledge from the DMA engine, active high |
| xfer_start | output | 1 | One-cycle transfer-start pulse |

## Verification
A pin change driven at a falling clock edge first shows at `xfer_start` after the fifth following rising edge. An acknowledge driven at a falling edge shows after the third following rising edge. The bench therefore samples `xfer_start` at falling edges, exactly that many edges after each stimulus, and checks the neighbouring edges for a low output to confirm the pulse lasts one cycle. A cycle-level reference in the bench keeps its own pin history and hold flag. It predicts `xfer_start` three cycles ahead through a small shift register, and its prediction is compared with the output at every falling edge during both the directed and the random phases.

// File: rtl/dma_req_sampler_pkg.sv
package dma_req_sampler_pkg;

  typedef enum logic {
    PH_SAMPLE = 1'b0,
    PH_HOLD   = 1'b1
  } smp_phase_e;

  // Whether the current synchronised sample qualifies as a request.
  function automatic logic req_qualifies(logic edge_sel, logic cur, logic old);
    return edge_sel ? (cur & ~old) : cur;
  endfunction

  // Whether a sample may be taken in this cycle.
  function automatic logic sample_allowed(smp_phase_e ph, logic ack);
    return (ph == PH_SAMPLE) | ack;
  endfunction

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in_n,
  output logic syn_cur,
  output logic syn_old
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain   <= '0;
      syn_old <= 1'b0;
    end else begin
      chain   <= {chain[STAGES-2:0], ~req_in_n};
      syn_old <= chain[STAGES-1];
    end
  end

  assign syn_cur = chain[STAGES-1];

endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect
  import dma_req_sampler_pkg::*;
#(
  parameter int WARM_EDGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_edge,
  input  logic ack_in,
  input  logic syn_cur,
  input  logic syn_old,
  output logic smp_det,
  output logic smp_hold,
  output logic smp_warm
);

  localparam int CW = $clog2(WARM_EDGES + 1);

  logic [CW-1:0] warm_cnt;
  smp_phase_e    phase;
  logic          smp_en;

  assign smp_warm = (warm_cnt == CW'(WARM_EDGES));
  assign smp_en   = smp_warm & sample_allowed(phase, ack_in);
  assign smp_det  = smp_en & req_qualifies(mode_edge, syn_cur, syn_old);
  assign smp_hold = (phase == PH_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_cnt <= '0;
    end else if (!smp_warm) begin
      warm_cnt <= warm_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SAMPLE;
    end else if (smp_det) begin
      phase <= PH_HOLD;
    end else if (ack_in) begin
      phase <= PH_SAMPLE;
    end
  end

endmodule

// File: rtl/dma_req_delay.sv
module dma_req_delay #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] pipe;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[DEPTH-1];

endmodule

// File: rtl/dma_req_sampler.sv
module dma_req_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int LAT_STATES  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in_n,
  input  logic mode_edge,
  input  logic ack_in,
  output logic xfer_start
);

  localparam int WARM_EDGES = SYNC_STAGES + 1;

  logic syn_cur;
  logic syn_old;
  logic smp_det;
  logic smp_hold;
  logic smp_warm;

  dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_in_n (req_in_n),
    .syn_cur  (syn_cur),
    .syn_old  (syn_old)
  );

  dma_req_detect #(.WARM_EDGES(WARM_EDGES)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_edge (mode_edge),
    .ack_in    (ack_in),
    .syn_cur   (syn_cur),
    .syn_old   (syn_old),
    .smp_det   (smp_det),
    .smp_hold  (smp_hold),
    .smp_warm  (smp_warm)
  );

  dma_req_delay #(.DEPTH(LAT_STATES)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (smp_det),
    .dout  (xfer_start)
  );

endmodule

// File: rtl/dma_req_sampler_chk.sv
module dma_req_sampler_chk #(
  parameter int STAGES = 2,
  parameter int LAT    = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_in_n,
  input logic mode_edge,
  input logic ack_in,
  input logic xfer_start,
  input logic smp_det,
  input logic smp_hold,
  input logic smp_warm
);

  AST_WARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_warm |-> !smp_det); // R8

  AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_hold && !ack_in) |-> !smp_det); // R6

  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    smp_det |=> smp_hold); // R7

  AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_hold && ack_in && !smp_det) |=> !smp_hold); // R7

  generate
    if (LAT == 3) begin : g_lat3
      AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start == $past(smp_det, 3)); // R2
    end
    if (STAGES == 2) begin : g_sync2
      AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_edge && smp_det) |-> (!$past(req_in_n, 2) && $past(req_in_n, 3))); // R4
      AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_edge && smp_det) |-> !$past(req_in_n, 2)); // R5
    end
  endgenerate

endmodule

bind dma_req_sampler dma_req_sampler_chk #(
  .STAGES (SYNC_STAGES),
  .LAT    (LAT_STATES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_in_n   (req_in_n),
  .mode_edge  (mode_edge),
  .ack_in     (ack_in),
  .xfer_start (xfer_start),
  .smp_det    (smp_det),
  .smp_hold   (smp_hold),
  .smp_warm   (smp_warm)
);

// File: tb/dma_req_sampler_bench.sv
module dma_req_sampler_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_in_n = 1'b1;
  logic mode_edge = 1'b1;
  logic ack_in = 1'b0;
  logic xfer_start;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_req_sampler u_dma_req_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_in_n   (req_in_n),
    .mode_edge  (mode_edge),
    .ack_in     (ack_in),
    .xfer_start (xfer_start)
  );

  // Reference: pin history per edge, hold flag, 3-deep prediction line.
  int   m_edges = 0;
  bit   m_hold = 1'b0;
  bit   h_a = 1'b0, h_b = 1'b0, h_c = 1'b0;
  bit   [2:0] m_sr = 3'b000;

  function automatic bit ref_qualify(bit edge_sel, bit now_low, bit was_low);
    if (edge_sel) return now_low && !was_low;
    return now_low;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_edges = 0; m_hold = 1'b0; m_sr = 3'b000;
      h_a = 1'b0; h_b = 1'b0; h_c = 1'b0;
    end else begin
      bit d;
      m_edges = m_edges + 1;
      d = (m_edges >= 4) && (!m_hold || ack_in) && ref_qualify(mode_edge, h_b, h_c);
      if (d) m_hold = 1'b1;
      else if (ack_in) m_hold = 1'b0;
      m_sr = {m_sr[1:0], d};
      h_c = h_b; h_b = h_a; h_a = !req_in_n;
    end
  end

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: xfer_start actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) check(xfer_start, 1'b0, "R1 reset");
      else check(xfer_start, m_sr[2], "R2 R3 R4 R5 R6 R7 model");
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (xfer_start) cnt++;
    end
  endtask

  task automatic ack_pulse();
    ack_in = 1'b1; tick(1); ack_in = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'd2024));
    @(negedge clk);
    tick(3);
    check(xfer_start, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    tick(6);

    // R2/R3 edge mode latency and single pulse
    req_in_n = 1'b0;
    tick(4); check(xfer_start, 1'b0, "R2 early");
    tick(1); check(xfer_start, 1'b1, "R2 due");
    tick(1); check(xfer_start, 1'b0, "R3 single");
    count_pulses(10, cnt); check(cnt != 0, 1'b0, "R4 held low no ack");
    ack_pulse();
    count_pulses(10, cnt); check(cnt != 0, 1'b0, "R4 held low after ack");

    // R7: resume after an ack sample with no edge
    req_in_n = 1'b1; tick(6);
    req_in_n = 1'b0; tick(6);
    req_in_n = 1'b1; tick(4);
    ack_pulse(); tick(3);
    req_in_n = 1'b0;
    tick(4); check(xfer_start, 1'b0, "R7 early");
    tick(1); check(xfer_start, 1'b1, "R7 resumed edge");

    // R6: edges during hold are ignored
    req_in_n = 1'b1; tick(2);
    for (int i = 0; i < 4; i++) begin
      req_in_n = 1'b0; tick(3);
      req_in_n = 1'b1; tick(3);
    end
    count_pulses(6, cnt); check(cnt != 0, 1'b0, "R6 edge mode hold");
    ack_pulse(); tick(6);

    // R5: level mode re-trigger on ack sample
    mode_edge = 1'b0; req_in_n = 1'b1; tick(6);
    req_in_n = 1'b0;
    tick(5); check(xfer_start, 1'b1, "R5 level first");
    count_pulses(10, cnt); check(cnt != 0, 1'b0, "R6 level hold");
    ack_in = 1'b1; tick(1); ack_in = 1'b0;
    tick(1); check(xfer_start, 1'b0, "R5 early");
    tick(1); check(xfer_start, 1'b1, "R5 retrigger");
    tick(1); check(xfer_start, 1'b0, "R3 level single");
    req_in_n = 1'b1; ack_pulse(); tick(6);

    // R8: pin low through reset release in edge mode
    mode_edge = 1'b1; req_in_n = 1'b0; rst_n = 1'b0; tick(3);
    rst_n = 1'b1;
    count_pulses(20, cnt); check(cnt != 0, 1'b0, "R8 low at release");
    req_in_n = 1'b1; tick(4);
    req_in_n = 1'b0; tick(5); check(xfer_start, 1'b1, "R8 later edge");
    req_in_n = 1'b1; ack_pulse(); tick(6);

    // Random phase against the reference
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) mode_edge = $urandom_range(0, 1);
      if ($urandom_range(0, 5) == 0) req_in_n = ~req_in_n;
      ack_in = ($urandom_range(0, 3) == 0);
      tick(1);
    end
    ack_in = 1'b0;
    tick(5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule